// File: doc/BRIEF.md
# NAND flash bus cycle sequencer

This block turns host requests into byte-wide cycles on an asynchronous 8-bit NAND flash bus. A request carries one of four operations: command byte, address byte, data write or data read. A data request may cover one byte or a 32-bit word. A word becomes four back-to-back byte cycles, taken from the low byte upward. Each byte cycle has three phases. In the first, the latch line (CLE for commands, ALE for addresses) is raised while the strobe stays high. In the second, the write or read strobe is driven low. In the third, the strobe is high again and the latch line is still held. The length of each phase is programmed in clock cycles, stored as count minus one.

Requests use a valid/ready channel. `req_ready` is high only when the block is idle and the global enable is set. A request is taken on a clock where `req_valid` and `req_ready` are both high. Completion is reported on a response channel. `rsp_valid` stays high, with `rsp_data` stable, until the host raises `rsp_ready`. No new request is accepted while a response is pending. Back-pressure therefore only stalls the host and never the flash. The configuration and control inputs are plain write strobes. The chip-enable bit drives the active-low chip select directly. The flash ready/busy pin is synchronised and presented as a status output.

Top module: `nfc_seq`

## Requirements
- R1: After reset, nand_ce_n=1, cle=ale=0, we_n=re_n=1, dq_oe=0 and rsp_valid=0. The phase fields hold their maximum codes (setup 3, strobe 7, hold 7), so the first cycle lasts 4+8+8 clocks.
- R2: While the enable bit is 0, req_ready stays 0 and no strobe, CLE or ALE activity appears, even with req_valid held high.
- R3: req_kind=0 (command) produces one byte cycle. CLE is high and ALE is low for every clock of its setup, strobe and hold phases. Both are low outside the cycle. Data cycles (kinds 2 and 3) keep both CLE and ALE low.
- R4: req_kind=1 (address) produces one byte cycle with ALE high and CLE low for the whole cycle. CLE and ALE are never high together.
- R5: A byte cycle lasts setup+1 clocks with the strobe high, then strobe+1 clocks with it low, then hold+1 clocks with it high. The strobe and hold fields are 3 bits wide. The setup field is SETUP_W bits wide (2 by default, 3 for the wider option).
- R6: A data write with req_word=1 makes four byte cycles carrying req_wdata[7:0], [15:8], [23:16] and [31:24] in that order. Command and address always make a single cycle from req_wdata[7:0], whatever req_word is.
- R7: A read (kind 3) samples nand_dq_i on the last clock of each strobe-low phase. A word read returns the bytes in rsp_data from bit 0 upward. A byte read returns the byte in rsp_data[7:0] with the upper bits zero.
- R8: nand_we_n goes low only in write-type cycles (kinds 0, 1 and 2), and nand_re_n only in reads. nand_dq_oe is high through every write-type cycle and never during a read. The two strobes are never low together.
- R9: nand_ce_n follows the last control write: 1 deselects the chip and 0 selects it.
- R10: flash_ready is 1 for a ready pin (nand_rb=1) and 0 for busy. It follows the pin through two flops, so a change shows after the second rising edge.
- R11: After acceptance, req_ready stays 0 until the response is taken. rsp_valid and rsp_data hold until rsp_ready is high. req_ready returns one clock after the response is taken.
- R12: Each phase loads its count from the timing register when that phase begins. A timing write in the same clock as request acceptance therefore leaves that cycle's setup at the old value, while its strobe and hold use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tim_we | input | 1 | Write strobe for the three phase fields |
| cfg_setup_in | input | SETUP_W | Setup phase length minus one |
| cfg_strobe_in | input | 3 | Strobe-low phase length minus one |
| cfg_hold_in | input | 3 | Hold phase length minus one |
| cfg_ctl_we | input | 1 | Write strobe for enable and chip-enable bits |
| cfg_enable_in | input | 1 | Global enable for bus cycles |
| cfg_ce_n_in | input | 1 | Chip-enable bit, 1 deselects |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle and enabled) |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_word | input | 1 | Data request covers four bytes |
| req_wdata | input | 32 | Command, address or write data |
| rsp_valid | output | 1 | Request completed |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Read data |
| flash_ready | output | 1 | Synchronised ready/busy status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin, 1 means ready |

## Verification
Two functions can fall on the same clock: a timing-register write and the acceptance of a request. The bench raises cfg_tim_we on the same clock as req_valid. It then measures the phase lengths of the resulting byte cycle on the bus. The setup length must match the old field value, and the strobe and hold lengths must match the new ones. A second overlap is a response held under back-pressure while new requests wait. The bench holds rsp_ready low for several clocks and checks that req_ready stays low and that rsp_data does not move.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RESP   = 3'd4
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nfc_cfg_regs.sv
module nfc_cfg_regs #(
  parameter int SETUP_W  = 2,
  parameter int STROBE_W = 3,
  parameter int HOLD_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tim_we,
  input  logic [SETUP_W-1:0]  setup_in,
  input  logic [STROBE_W-1:0] strobe_in,
  input  logic [HOLD_W-1:0]   hold_in,
  input  logic                ctl_we,
  input  logic                en_in,
  input  logic                ce_n_in,
  output logic [SETUP_W-1:0]  setup_q,
  output logic [STROBE_W-1:0] strobe_q,
  output logic [HOLD_W-1:0]   hold_q,
  output logic                en_q,
  output logic                ce_n_q
);

  // timing fields: safest (longest) values out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= '1;
      strobe_q <= '1;
      hold_q   <= '1;
    end else if (tim_we) begin
      setup_q  <= setup_in;
      strobe_q <= strobe_in;
      hold_q   <= hold_in;
    end
  end

  // control bits: disabled, chip deselected out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ce_n_q <= 1'b1;
    end else if (ctl_we) begin
      en_q   <= en_in;
      ce_n_q <= ce_n_in;
    end
  end

endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];

endmodule

// File: rtl/nfc_phase_fsm.sv
module nfc_phase_fsm
  import nfc_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int BYTES = 4,
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] strobe_cnt,
  input  logic [CNT_W-1:0] hold_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  op_e              req_op,
  input  logic             req_word,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output op_e              op_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             active,
  output logic             strobe_on,
  output logic             cap,
  output logic             load
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] last_q;
  logic             multi;
  logic             cnt_zero;

  assign req_ready = (phase_q == PH_IDLE) && en;
  assign load      = req_valid && req_ready;
  assign multi     = req_word && ((req_op == OP_WR) || (req_op == OP_RD));
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      op_q    <= OP_CMD;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (load) begin
            op_q    <= req_op;
            idx_q   <= '0;
            last_q  <= multi ? IDX_W'(BYTES - 1) : '0;
            cnt_q   <= setup_cnt;
            phase_q <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            cnt_q   <= strobe_cnt;
            phase_q <= PH_STROBE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            cnt_q   <= hold_cnt;
            phase_q <= PH_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (idx_q == last_q) begin
            phase_q <= PH_RESP;
          end else begin
            idx_q   <= idx_q + 1'b1;
            cnt_q   <= setup_cnt;
            phase_q <= PH_SETUP;
          end
        end
        PH_RESP: begin
          if (rsp_ready) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active    = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) ||
                     (phase_q == PH_HOLD);
  assign strobe_on = (phase_q == PH_STROBE);
  assign cap       = strobe_on && cnt_zero && (op_q == OP_RD);
  assign rsp_valid = (phase_q == PH_RESP);

endmodule

// File: rtl/nfc_byte_lane.sv
module nfc_byte_lane #(
  parameter int BYTES = 4,
  localparam int DATA_W = 8 * BYTES,
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic              cap,
  input  logic [7:0]        dq_in,
  output logic [7:0]        tx_byte,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wdata_q <= '0;
    else if (load) wdata_q <= wdata;
  end

  // receive side: one register per byte lane, cleared per request
  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rdata_q[8*g +: 8] <= '0;
        else if (load)
          rdata_q[8*g +: 8] <= '0;
        else if (cap && (idx == IDX_W'(g)))
          rdata_q[8*g +: 8] <= dq_in;
      end
    end
  endgenerate

  always_comb begin
    tx_byte = wdata_q[7:0];
    for (int b = 0; b < BYTES; b++) begin
      if (idx == IDX_W'(b)) tx_byte = wdata_q[8*b +: 8];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int SETUP_W  = 2,
  parameter int STROBE_W = 3,
  parameter int HOLD_W   = 3,
  parameter int BYTES    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_tim_we,
  input  logic [SETUP_W-1:0]  cfg_setup_in,
  input  logic [STROBE_W-1:0] cfg_strobe_in,
  input  logic [HOLD_W-1:0]   cfg_hold_in,
  input  logic                cfg_ctl_we,
  input  logic                cfg_enable_in,
  input  logic                cfg_ce_n_in,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic                req_word,
  input  logic [8*BYTES-1:0]  req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [8*BYTES-1:0]  rsp_data,
  output logic                flash_ready,
  output logic                nand_ce_n,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic [7:0]          nand_dq_o,
  output logic                nand_dq_oe,
  input  logic [7:0]          nand_dq_i,
  input  logic                nand_rb
);

  localparam int CNT_W = max3(SETUP_W, STROBE_W, HOLD_W);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [SETUP_W-1:0]  setup_q;
  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;
  logic                en_q;
  logic                ce_n_q;
  op_e                 op_q;
  logic [IDX_W-1:0]    idx;
  logic                active;
  logic                strobe_on;
  logic                cap;
  logic                load;
  logic                is_read;

  nfc_cfg_regs #(
    .SETUP_W (SETUP_W),
    .STROBE_W(STROBE_W),
    .HOLD_W  (HOLD_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .tim_we   (cfg_tim_we),
    .setup_in (cfg_setup_in),
    .strobe_in(cfg_strobe_in),
    .hold_in  (cfg_hold_in),
    .ctl_we   (cfg_ctl_we),
    .en_in    (cfg_enable_in),
    .ce_n_in  (cfg_ce_n_in),
    .setup_q  (setup_q),
    .strobe_q (strobe_q),
    .hold_q   (hold_q),
    .en_q     (en_q),
    .ce_n_q   (ce_n_q)
  );

  nfc_phase_fsm #(
    .CNT_W(CNT_W),
    .BYTES(BYTES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .setup_cnt (CNT_W'(setup_q)),
    .strobe_cnt(CNT_W'(strobe_q)),
    .hold_cnt  (CNT_W'(hold_q)),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (op_e'(req_kind)),
    .req_word  (req_word),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .op_q      (op_q),
    .idx_q     (idx),
    .active    (active),
    .strobe_on (strobe_on),
    .cap       (cap),
    .load      (load)
  );

  nfc_byte_lane #(
    .BYTES(BYTES)
  ) u_lane (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .wdata  (req_wdata),
    .idx    (idx),
    .cap    (cap),
    .dq_in  (nand_dq_i),
    .tx_byte(nand_dq_o),
    .rdata  (rsp_data)
  );

  nfc_rb_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rb (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (nand_rb),
    .level(flash_ready)
  );

  assign is_read    = (op_q == OP_RD);
  assign nand_ce_n  = ce_n_q;
  assign nand_cle   = active && (op_q == OP_CMD);
  assign nand_ale   = active && (op_q == OP_ADDR);
  assign nand_we_n  = !(strobe_on && !is_read);
  assign nand_re_n  = !(strobe_on && is_read);
  assign nand_dq_oe = active && !is_read;

endmodule

// File: rtl/nfc_seq_chk.sv
module nfc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_dq_oe
);

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R8

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R8

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R8

  AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> en_q); // R2

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

endmodule

bind nfc_seq nfc_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_we_n (nand_we_n),
  .nand_re_n (nand_re_n),
  .nand_dq_oe(nand_dq_oe)
);

// File: tb/tb_nfc_seq.sv
module tb_nfc_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tim_we = 1'b0;
  logic [1:0]  cfg_setup_in = '0;
  logic [2:0]  cfg_strobe_in = '0;
  logic [2:0]  cfg_hold_in = '0;
  logic        cfg_ctl_we = 1'b0;
  logic        cfg_enable_in = 1'b0;
  logic        cfg_ce_n_in = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_word = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        flash_ready;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nfc_seq dut (.*);

  // vector: [43:42] kind, [41] word, [40:38] setup, [37:35] strobe, [34:32] hold, [31:0] data
  localparam logic [43:0] VEC [7] = '{
    {2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 32'h0000_0070},
    {2'd1, 1'b0, 3'd1, 3'd2, 3'd0, 32'h0000_005A},
    {2'd2, 1'b0, 3'd3, 3'd1, 3'd2, 32'h0000_00C3},
    {2'd2, 1'b1, 3'd0, 3'd0, 3'd1, 32'h1122_3344},
    {2'd3, 1'b1, 3'd2, 3'd3, 3'd0, 32'hDEAD_BEEF},
    {2'd3, 1'b0, 3'd0, 3'd7, 3'd0, 32'h0000_00A5},
    {2'd0, 1'b1, 3'd1, 3'd1, 3'd1, 32'h1234_56FF}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_tim(input int s, input int t, input int h);
    @(negedge clk);
    cfg_tim_we    = 1'b1;
    cfg_setup_in  = 2'(s);
    cfg_strobe_in = 3'(t);
    cfg_hold_in   = 3'(h);
    @(negedge clk);
    cfg_tim_we = 1'b0;
  endtask

  task automatic set_ctl(input bit en, input bit ce_n);
    @(negedge clk);
    cfg_ctl_we    = 1'b1;
    cfg_enable_in = en;
    cfg_ce_n_in   = ce_n;
    @(negedge clk);
    cfg_ctl_we = 1'b0;
  endtask

  // issue one request, record the bus every clock, compare with the expected frame
  task automatic run_req(input logic [1:0] kind, input bit word, input logic [31:0] data,
                         input int s, input int t, input int h,
                         input bit same_cfg, input int ns, input int nt, input int nh,
                         input string tag);
    int nbytes, per, n, b, p;
    int e_tim, e_ctl, e_dq, e_dir;
    bit got, exp_lo, lo, other;
    logic [31:0] exp_rd;
    string ctl_rq;
    nbytes = ((kind >= 2'd2) && word) ? 4 : 1;
    per = s + t + h + 3;
    n = 0; e_tim = 0; e_ctl = 0; e_dq = 0; e_dir = 0; got = 1'b0;
    ctl_rq = (kind == 2'd1) ? "R4" : "R3";
    @(negedge clk);
    chk(req_ready, "R11", {tag, " ready before request"}, req_ready, 1);
    req_valid = 1'b1;
    req_kind  = kind;
    req_word  = word;
    req_wdata = data;
    if (same_cfg) begin
      cfg_tim_we    = 1'b1;
      cfg_setup_in  = 2'(ns);
      cfg_strobe_in = 3'(nt);
      cfg_hold_in   = 3'(nh);
    end
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      req_valid  = 1'b0;
      cfg_tim_we = 1'b0;
      if (rsp_valid) begin
        got = 1'b1;
        break;
      end
      b = n / per;
      p = n % per;
      exp_lo = (p >= s + 1) && (p < s + t + 2);
      if (b >= nbytes) begin
        e_tim++;
      end else begin
        lo    = (kind == 2'd3) ? !nand_re_n : !nand_we_n;
        other = (kind == 2'd3) ? !nand_we_n : !nand_re_n;
        if (lo != exp_lo) e_tim++;
        if (other) e_dir++;
        if (nand_dq_oe != (kind != 2'd3)) e_dir++;
        if (nand_cle != (kind == 2'd0) || nand_ale != (kind == 2'd1)) e_ctl++;
        if (kind != 2'd3 && nand_dq_o != data[8*b +: 8]) e_dq++;
        if (kind == 2'd3 && exp_lo && p == s + 1) nand_dq_i = data[8*b +: 8];
      end
      n++;
    end
    chk(got && n == nbytes * per, "R5", {tag, " clocks to completion"}, n, nbytes * per);
    chk(e_tim == 0, "R5", {tag, " strobe phase mismatches"}, e_tim, 0);
    chk(e_ctl == 0, ctl_rq, {tag, " CLE/ALE mismatches"}, e_ctl, 0);
    chk(e_dir == 0, "R8", {tag, " strobe/direction mismatches"}, e_dir, 0);
    if (kind != 2'd3)
      chk(e_dq == 0, "R6", {tag, " write byte mismatches"}, e_dq, 0);
    else begin
      exp_rd = word ? data : {24'h0, data[7:0]};
      chk(rsp_data == exp_rd, "R7", {tag, " read data"}, rsp_data, exp_rd);
    end
    // back-pressure on the response
    repeat (2) @(negedge clk);
    chk(rsp_valid && !req_ready, "R11", {tag, " response held"}, {rsp_valid, req_ready}, 2'b10);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R11", {tag, " ready after take"}, {rsp_valid, req_ready}, 2'b01);
    chk(!nand_cle && !nand_ale, "R3", {tag, " latches low after cycle"}, {nand_cle, nand_ale}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int stuck;
    logic [43:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 1'b1, "R1", "ce_n after reset", nand_ce_n, 1);
    chk({nand_cle, nand_ale} == 2'b00, "R1", "cle/ale after reset", {nand_cle, nand_ale}, 0);
    chk({nand_we_n, nand_re_n} == 2'b11, "R1", "strobes after reset", {nand_we_n, nand_re_n}, 3);
    chk(!nand_dq_oe && !rsp_valid, "R1", "oe/rsp after reset", {nand_dq_oe, rsp_valid}, 0);

    // R2 disabled: request must stay pending, bus idle
    req_valid = 1'b1; req_kind = 2'd0; req_wdata = 32'h90;
    stuck = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (req_ready || nand_cle || nand_ale || !nand_we_n || !nand_re_n) stuck++;
    end
    req_valid = 1'b0;
    chk(stuck == 0, "R2", "activity while disabled", stuck, 0);

    // R1 default timing 4/8/8 on the first enabled cycle
    set_ctl(1'b1, 1'b1);
    run_req(2'd0, 1'b0, 32'hFF, 3, 7, 7, 1'b0, 0, 0, 0, "R1 default timing");

    // vector table
    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      set_tim(int'(v[40:38]), int'(v[37:35]), int'(v[34:32]));
      run_req(v[43:42], v[41], v[31:0], int'(v[40:38]), int'(v[37:35]), int'(v[34:32]),
              1'b0, 0, 0, 0, $sformatf("vec%0d", i));
    end

    // R12 timing write in the accept clock: old setup 1, new strobe 0, new hold 2
    set_tim(1, 1, 1);
    run_req(2'd1, 1'b0, 32'h3C, 1, 0, 2, 1'b1, 3, 0, 2, "R12 same-clock config");

    // R9 chip enable
    set_ctl(1'b1, 1'b0);
    chk(nand_ce_n == 1'b0, "R9", "ce_n selected", nand_ce_n, 0);
    set_ctl(1'b1, 1'b1);
    chk(nand_ce_n == 1'b1, "R9", "ce_n released", nand_ce_n, 1);

    // R10 ready/busy status through two flops
    @(negedge clk);
    chk(flash_ready == 1'b1, "R10", "ready level", flash_ready, 1);
    nand_rb = 1'b0;
    @(negedge clk);
    chk(flash_ready == 1'b1, "R10", "busy after one edge", flash_ready, 1);
    @(negedge clk);
    chk(flash_ready == 1'b0, "R10", "busy after two edges", flash_ready, 0);
    nand_rb = 1'b1;
    repeat (2) @(negedge clk);
    chk(flash_ready == 1'b1, "R10", "ready again", flash_ready, 1);

    // R2 disabling again closes the request channel
    set_ctl(1'b0, 1'b1);
    chk(!req_ready, "R2", "ready after disable", req_ready, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule